// File: doc/BRIEF.md
# Incremental ADC Result Accumulator and Normaliser

This block turns the one-bit stream of an incremental sigma-delta modulator into a finished conversion word. A sequencer divides a conversion into 2^NEL elementary conversions of 8·2^OSR samples each. It marks the start of the sequence, the end of each elementary conversion and the end of the sequence. For each elementary conversion the block counts the modulator bit as +1 or −1 on every sample strobe. The sequencer alternates the analog input polarity between elementary conversions, and the block subtracts the count of each crossed conversion instead of adding it. Converter offset therefore cancels across a pair of conversions.

When the sequence ends, the block scales the running total so that the mean of the elementary results becomes a 16-bit two's complement fraction of full scale. It saturates that value to the full-scale codes. It keeps only as many leading bits as the settings resolve and fills the bits below them with a fixed marker pattern. The word lands in a result register and a one-cycle valid strobe follows.

Top module: `incadc_result`

## Requirements
- R1: A synchronous active-high reset clears the result to 0x0000 and drops the valid strobe.
- R2: On each cycle with the sample strobe high, a modulator bit of 1 adds one to the elementary count and a bit of 0 subtracts one.
- R3: When the elementary-end marker arrives with the crossed flag high, that elementary count is subtracted from the sequence total. With the flag low it is added.
- R4: The unsaturated code equals the sequence total shifted left by 12 − OSR − NEL. This is the mean of the elementary results, where full scale (2^NEL · 8·2^OSR) maps to 2^15.
- R5: The effective resolution is 6 + 2·OSR + NEL bits, capped at 16.
- R6: When the resolution is below 16 bits, only the top resolution bits of the saturated code are kept. The bit just below them reads 1 and every lower bit reads 0, so at 13 bits, bits 2..0 read 100.
- R7: Codes above 0x7FFF become 0x7FFF and codes below −32768 become 0x8000, before the fill of R6 is applied.
- R8: The sequence-start marker clears both the elementary count and the sequence total, so nothing from an earlier, unfinished sequence survives.
- R9: The result register changes only on the clock edge that samples the sequence-end marker. The valid strobe is high for exactly the cycle that follows such an edge. At all other times the result holds.
- R10: The modulator bit has no effect on cycles where the sample strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit_i | input | 1 | Modulator output bit |
| samp_stb_i | input | 1 | Sample strobe qualifying mod_bit_i |
| chop_i | input | 1 | High when the ending elementary conversion used crossed inputs |
| seq_start_i | input | 1 | Sequence-start marker |
| elem_done_i | input | 1 | Elementary-conversion-end marker |
| seq_done_i | input | 1 | Sequence-end marker |
| osr_i | input | 3 | Oversampling exponent, 8·2^osr samples per elementary conversion |
| nel_i | input | 2 | Elementary conversion exponent, 2^nel per sequence |
| result_o | output | 16 | Normalised two's complement result |
| result_vld_o | output | 1 | One-cycle strobe after a result update |

## Verification
The bench builds the block with its default parameters: a 3-bit oversampling exponent, a 2-bit count exponent, a 16-bit word and a 6-bit base resolution. With these settings every resolution from 6 bits up to the 16-bit cap can be reached. One vector uses OSR 7 with NEL 3, the largest setting, where a sequence of 8192 samples exercises the widest accumulator and a resolution formula that exceeds the cap. Saturation is reached at both the coarsest (6-bit) and the full 16-bit resolution. Sequences with crossed conversions and equal raw counts check that offset cancels to an exact zero.

// File: rtl/incadc_pkg.sv
package incadc_pkg;

    localparam int OSR_W_DEF     = 3;
    localparam int NEL_W_DEF     = 2;
    localparam int OUT_W_DEF     = 16;
    localparam int SMAX_LOG0_DEF = 3;
    localparam int RES_BASE_DEF  = 6;

    typedef struct packed {
        logic start;
        logic elem_end;
        logic seq_end;
        logic crossed;
    } phase_t;

    // signed width holding +/- 2^(log0 + largest osr)
    function automatic int elem_width(int log0, int osr_w);
        return log0 + (2 ** osr_w - 1) + 2;
    endfunction

    // signed width holding the sum of the largest number of elementary results
    function automatic int tot_width(int elem_w, int nel_w);
        return elem_w + (2 ** nel_w - 1);
    endfunction

endpackage

// File: rtl/incadc_elem_acc.sv
module incadc_elem_acc #(
    parameter int ELEM_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     stb,
    input  logic                     bit_i,
    output logic signed [ELEM_W-1:0] sum_o
);

    localparam logic signed [ELEM_W-1:0] ONE = ELEM_W'(1);

    logic signed [ELEM_W-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= '0;
        end else if (stb) begin
            sum_q <= bit_i ? (sum_q + ONE) : (sum_q - ONE);
        end
    end

    assign sum_o = sum_q;

endmodule

// File: rtl/incadc_seq_acc.sv
module incadc_seq_acc #(
    parameter int ELEM_W = 12,
    parameter int TOT_W  = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     add_en,
    input  logic                     negate,
    input  logic signed [ELEM_W-1:0] elem_i,
    output logic signed [TOT_W-1:0]  tot_o
);

    localparam int EXT = TOT_W - ELEM_W;

    logic signed [TOT_W-1:0] elem_ext;
    logic signed [TOT_W-1:0] tot_q;

    assign elem_ext = {{EXT{elem_i[ELEM_W-1]}}, elem_i};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tot_q <= '0;
        end else if (add_en) begin
            tot_q <= negate ? (tot_q - elem_ext) : (tot_q + elem_ext);
        end
    end

    assign tot_o = tot_q;

endmodule

// File: rtl/incadc_format.sv
module incadc_format #(
    parameter int TOT_W     = 15,
    parameter int OUT_W     = 16,
    parameter int OSR_W     = 3,
    parameter int NEL_W     = 2,
    parameter int SMAX_LOG0 = 3,
    parameter int RES_BASE  = 6
) (
    input  logic signed [TOT_W-1:0] tot_i,
    input  logic [OSR_W-1:0]        osr_i,
    input  logic [NEL_W-1:0]        nel_i,
    output logic [OUT_W-1:0]        code_o
);

    localparam int OSR_MAX = 2 ** OSR_W - 1;
    localparam int NEL_MAX = 2 ** NEL_W - 1;
    localparam int SH_BASE = OUT_W - 1 - SMAX_LOG0;
    localparam int RAW_W   = TOT_W + SH_BASE;
    localparam int RES_MAX = RES_BASE + 2 * OSR_MAX + NEL_MAX;

    localparam logic signed [RAW_W-1:0] POS_FS =
        {{(RAW_W - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
    localparam logic signed [RAW_W-1:0] NEG_FS =
        {{(RAW_W - OUT_W + 1){1'b1}}, {(OUT_W - 1){1'b0}}};

    int res_full;
    int res_eff;
    int sh_amt;

    logic signed [RAW_W-1:0] raw_ext;
    logic signed [RAW_W-1:0] raw;
    logic [OUT_W-1:0]        sat;
    logic [OUT_W-1:0]        keep_m;
    logic [OUT_W-1:0]        fill_m;

    assign res_full = RES_BASE + 2 * int'(osr_i) + int'(nel_i);
    assign sh_amt   = SH_BASE - int'(osr_i) - int'(nel_i);

    generate
        if (RES_MAX > OUT_W) begin : g_cap
            assign res_eff = (res_full > OUT_W) ? OUT_W : res_full;
        end else begin : g_nocap
            assign res_eff = res_full;
        end
    endgenerate

    assign raw_ext = {{SH_BASE{tot_i[TOT_W-1]}}, tot_i};
    assign raw     = raw_ext <<< sh_amt;

    always_comb begin
        if (raw > POS_FS) begin
            sat = {1'b0, {(OUT_W - 1){1'b1}}};
        end else if (raw < NEG_FS) begin
            sat = {1'b1, {(OUT_W - 1){1'b0}}};
        end else begin
            sat = raw[OUT_W-1:0];
        end

        if (res_eff >= OUT_W) begin
            keep_m = '1;
            fill_m = '0;
        end else begin
            keep_m = {OUT_W{1'b1}} << (OUT_W - res_eff);
            fill_m = {{(OUT_W - 1){1'b0}}, 1'b1} << (OUT_W - 1 - res_eff);
        end

        code_o = (sat & keep_m) | fill_m;
    end

endmodule

// File: rtl/incadc_result.sv
module incadc_result
    import incadc_pkg::*;
#(
    parameter int OSR_W     = OSR_W_DEF,
    parameter int NEL_W     = NEL_W_DEF,
    parameter int OUT_W     = OUT_W_DEF,
    parameter int SMAX_LOG0 = SMAX_LOG0_DEF,
    parameter int RES_BASE  = RES_BASE_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_bit_i,
    input  logic             samp_stb_i,
    input  logic             chop_i,
    input  logic             seq_start_i,
    input  logic             elem_done_i,
    input  logic             seq_done_i,
    input  logic [OSR_W-1:0] osr_i,
    input  logic [NEL_W-1:0] nel_i,
    output logic [OUT_W-1:0] result_o,
    output logic             result_vld_o
);

    localparam int ELEM_W = elem_width(SMAX_LOG0, OSR_W);
    localparam int TOT_W  = tot_width(ELEM_W, NEL_W);

    phase_t                   ph;
    logic signed [ELEM_W-1:0] elem_sum;
    logic signed [TOT_W-1:0]  tot_sum;
    logic [OUT_W-1:0]         code;
    logic [OUT_W-1:0]         result_q;
    logic                     vld_q;

    assign ph = '{start: seq_start_i, elem_end: elem_done_i,
                  seq_end: seq_done_i, crossed: chop_i};

    incadc_elem_acc #(
        .ELEM_W (ELEM_W)
    ) u_elem (
        .clk   (clk),
        .rst   (rst),
        .clr   (ph.start || ph.elem_end),
        .stb   (samp_stb_i),
        .bit_i (mod_bit_i),
        .sum_o (elem_sum)
    );

    incadc_seq_acc #(
        .ELEM_W (ELEM_W),
        .TOT_W  (TOT_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .clr    (ph.start),
        .add_en (ph.elem_end),
        .negate (ph.crossed),
        .elem_i (elem_sum),
        .tot_o  (tot_sum)
    );

    incadc_format #(
        .TOT_W     (TOT_W),
        .OUT_W     (OUT_W),
        .OSR_W     (OSR_W),
        .NEL_W     (NEL_W),
        .SMAX_LOG0 (SMAX_LOG0),
        .RES_BASE  (RES_BASE)
    ) u_fmt (
        .tot_i  (tot_sum),
        .osr_i  (osr_i),
        .nel_i  (nel_i),
        .code_o (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= ph.seq_end;
            if (ph.seq_end) begin
                result_q <= code;
            end
        end
    end

    assign result_o     = result_q;
    assign result_vld_o = vld_q;

endmodule

// File: rtl/incadc_result_chk.sv
module incadc_result_chk #(
    parameter int OSR_W    = 3,
    parameter int NEL_W    = 2,
    parameter int OUT_W    = 16,
    parameter int RES_BASE = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             seq_done_i,
    input logic [OSR_W-1:0] osr_i,
    input logic [NEL_W-1:0] nel_i,
    input logic [OUT_W-1:0] result_o,
    input logic             result_vld_o
);

    logic [OSR_W-1:0] osr_q;
    logic [NEL_W-1:0] nel_q;
    logic             rst_q;
    int               res_raw;
    int               res_chk;
    logic [OUT_W-1:0] tail;

    always_ff @(posedge clk) begin
        osr_q <= osr_i;
        nel_q <= nel_i;
        rst_q <= rst;
    end

    assign res_raw = RES_BASE + 2 * int'(osr_q) + int'(nel_q);
    assign res_chk = (res_raw > OUT_W) ? OUT_W : res_raw;
    assign tail    = result_o << res_chk;

    always_ff @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_CLEAR: assert (!result_vld_o && result_o == '0); // R1
        end
    end

    AST_VALID_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst)
        seq_done_i |=> result_vld_o); // R9

    AST_VALID_ONLY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        !seq_done_i |=> !result_vld_o); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !seq_done_i |=> $stable(result_o)); // R9

    AST_FILL_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (result_vld_o && res_chk < OUT_W) |-> (tail == {1'b1, {(OUT_W - 1){1'b0}}})); // R6

endmodule

bind incadc_result incadc_result_chk #(
    .OSR_W    (OSR_W),
    .NEL_W    (NEL_W),
    .OUT_W    (OUT_W),
    .RES_BASE (RES_BASE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .seq_done_i   (seq_done_i),
    .osr_i        (osr_i),
    .nel_i        (nel_i),
    .result_o     (result_o),
    .result_vld_o (result_vld_o)
);

// File: tb/test_incadc_result.sv
module test_incadc_result;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_bit = 1'b0;
    logic        samp_stb = 1'b0;
    logic        chop = 1'b0;
    logic        seq_start = 1'b0;
    logic        elem_done = 1'b0;
    logic        seq_done = 1'b0;
    logic [2:0]  osr = 3'd0;
    logic [1:0]  nel = 2'd0;
    logic [15:0] result;
    logic        result_vld;

    int   total = 0;
    int   bad = 0;
    logic [15:0] prev = 16'h0000;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    incadc_result i_incadc_result (
        .clk          (clk),
        .rst          (rst),
        .mod_bit_i    (mod_bit),
        .samp_stb_i   (samp_stb),
        .chop_i       (chop),
        .seq_start_i  (seq_start),
        .elem_done_i  (elem_done),
        .seq_done_i   (seq_done),
        .osr_i        (osr),
        .nel_i        (nel),
        .result_o     (result),
        .result_vld_o (result_vld)
    );

    // fields: osr[43:41] nel[40:39] alternate[38] ones_direct[37:27] ones_crossed[26:16] expected[15:0]
    localparam int NVEC = 14;
    localparam logic [43:0] VEC [NVEC] = '{
        {3'd0, 2'd0, 1'b0, 11'd8,   11'd0,  16'h7E00},
        {3'd0, 2'd0, 1'b0, 11'd0,   11'd0,  16'h8200},
        {3'd0, 2'd0, 1'b0, 11'd4,   11'd0,  16'h0200},
        {3'd0, 2'd0, 1'b0, 11'd5,   11'd0,  16'h2200},
        {3'd1, 2'd1, 1'b1, 11'd10,  11'd6,  16'h2040},
        {3'd1, 2'd1, 1'b1, 11'd10,  11'd10, 16'h0040},
        {3'd2, 2'd2, 1'b1, 11'd20,  11'd12, 16'h2008},
        {3'd5, 2'd0, 1'b0, 11'd256, 11'd0,  16'h7FFF},
        {3'd5, 2'd0, 1'b0, 11'd0,   11'd0,  16'h8000},
        {3'd5, 2'd0, 1'b0, 11'd129, 11'd0,  16'h0100},
        {3'd3, 2'd3, 1'b1, 11'd40,  11'd40, 16'h0001},
        {3'd3, 2'd3, 1'b0, 11'd33,  11'd0,  16'h0401},
        {3'd1, 2'd0, 1'b0, 11'd7,   11'd0,  16'hF080},
        {3'd7, 2'd3, 1'b0, 11'd513, 11'd0,  16'h0040}
    };

    function automatic string vec_tag(int idx);
        case (idx)
            0, 1, 7, 8: return "R7 saturation";
            2:          return "R2 zero mean";
            3:          return "R2 R4 scaling";
            4, 5, 6:    return "R3 crossed subtraction";
            9, 13:      return "R5 resolution";
            10, 12:     return "R6 fill";
            default:    return "R4 mean";
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic feed_elem(int smax, int ones, bit crossed, bit noise);
        for (int s = 0; s < smax; s++) begin
            mod_bit  = (s < ones);
            samp_stb = 1'b1;
            tick();
            samp_stb = 1'b0;
            if (noise) begin
                mod_bit = 1'b1;
                tick();
            end
        end
        mod_bit   = 1'b0;
        chop      = crossed;
        elem_done = 1'b1;
        tick();
        elem_done = 1'b0;
        chop      = 1'b0;
    endtask

    task automatic run_conv(int o, int n, bit alt, int od, int oc, bit noise,
                            logic [15:0] exp, string tag);
        int smax;
        int nconv;
        smax  = 8 << o;
        nconv = 1 << n;
        osr   = 3'(o);
        nel   = 2'(n);
        seq_start = 1'b1;
        tick();
        seq_start = 1'b0;
        for (int i = 0; i < nconv; i++) begin
            bit crossed;
            crossed = alt && ((i % 2) == 1);
            feed_elem(smax, crossed ? oc : od, crossed, noise);
        end
        chk16("R9 result held during conversion", result, prev);
        chk1("R9 valid low during conversion", result_vld, 1'b0);
        seq_done = 1'b1;
        tick();
        seq_done = 1'b0;
        chk1("R9 valid after sequence end", result_vld, 1'b1);
        chk16(tag, result, exp);
        tick();
        chk1("R9 valid is a single pulse", result_vld, 1'b0);
        chk16("R9 result holds after pulse", result, exp);
        prev = exp;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) tick();
        chk16("R1 reset result", result, 16'h0000);
        chk1("R1 reset valid", result_vld, 1'b0);
        rst = 1'b0;
        tick();

        for (int v = 0; v < NVEC; v++) begin
            run_conv(int'(VEC[v][43:41]), int'(VEC[v][40:39]), VEC[v][38],
                     int'(VEC[v][37:27]), int'(VEC[v][26:16]), 1'b0,
                     VEC[v][15:0], vec_tag(v));
        end

        // R10: modulator ones on idle cycles must not count
        run_conv(0, 0, 1'b0, 5, 0, 1'b1, 16'h2200, "R10 bits without strobe ignored");

        // R8: leftover partial sequence is discarded by the next start marker
        osr = 3'd0;
        nel = 2'd0;
        seq_start = 1'b1;
        tick();
        seq_start = 1'b0;
        feed_elem(8, 8, 1'b0, 1'b0);
        feed_elem(8, 8, 1'b0, 1'b0);
        run_conv(0, 0, 1'b0, 1, 0, 1'b0, 16'hA200, "R8 start clears accumulators");

        // R1: reset after a nonzero result
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk16("R1 reset clears held result", result, 16'h0000);
        chk1("R1 reset clears valid", result_vld, 1'b0);
        prev = 16'h0000;
        tick();

        run_conv(1, 1, 1'b1, 10, 6, 1'b0, 16'h2040, "R3 after reset");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule